// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block is a small register file in which all transfers go over one shared bus. A source select code picks one register, or the external data input, and places it on the bus. Codes that name no source drive zero. The bus value then passes through a one-stage operation unit. That unit can forward the value unchanged, add one to it, or move it by one bit in either direction. The unit's result goes to every register, and each register has its own load enable, so any set of registers can take the same result on the same clock edge.

A sequencer outside the block drives the select, operation and load controls, one transfer per clock cycle. A conditional transfer such as "when K holds, R2 takes R1" needs no extra logic here. The sequencer sets the select code to R1 and drives the R2 load enable with K. The bus is always visible at an output, and the register contents are brought out as a flat vector so the surrounding logic can read them.

Top module: `bus_xfer_dp`

## Requirements
- R1: A high `rst` sampled at a rising clock edge sets every register to zero on that edge. Reset takes priority over any load enable.
- R2: When `src_sel` holds a value k below NUM_REGS, `bus_out` equals register k. This output is combinational and appears in the same cycle.
- R3: When `src_sel` equals NUM_REGS (4 by default), `bus_out` equals `ext_data`.
- R4: When `src_sel` is above NUM_REGS (5, 6 or 7 by default), `bus_out` is zero, and a register that loads in that cycle receives the operation applied to zero.
- R5: At a rising edge, with reset low, a register whose `load_en` bit is set takes the operation result. A register whose bit is clear keeps its value.
- R6: Several `load_en` bits may be set in one cycle, and each of those registers takes the same result.
- R7: `uop` = 2'b00 forwards the bus value unchanged.
- R8: `uop` = 2'b01 loads the bus value plus one, modulo 2^DATA_W, so the all-ones value becomes zero.
- R9: `uop` = 2'b10 moves the bus value one bit toward the MSB. The MSB is lost and the LSB becomes zero.
- R10: `uop` = 2'b11 moves the bus value one bit toward the LSB. The LSB is lost and the MSB becomes zero.
- R11: A register that is both the selected source and a destination takes the new value on the edge. Other destinations in that cycle receive a result computed from its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | SEL_W (3) | Bus source code: 0..NUM_REGS-1 selects a register, NUM_REGS selects `ext_data`, any other value selects zero |
| uop | input | 2 | Operation code: 00 pass, 01 increment, 10 shift toward MSB, 11 shift toward LSB |
| load_en | input | NUM_REGS (4) | Per-register load enable; bit i controls register i |
| ext_data | input | DATA_W (8) | External value that can be placed on the bus |
| bus_out | output | DATA_W (8) | Current bus value, combinational |
| regs_out | output | NUM_REGS*DATA_W (32) | All register contents; register i occupies bits [i*DATA_W +: DATA_W] |

## Verification
A register holding a wrong value shows up on `regs_out` one edge after the faulty load, or at once on the bus the next time that register is selected. A wrong select decode shows on `bus_out` in the same cycle, before any edge. A load that reads the value after the update instead of before it, or a wrong operation, changes the captured value by the next edge. The bench compares every register and the bus against its own model on every cycle, so any such fault is reported within one clock.

// File: rtl/bus_dp_pkg.sv
package bus_dp_pkg;

   // Operation codes applied between the bus and the register inputs
   typedef enum logic [1:0] {
      UOP_PASS = 2'b00,
      UOP_INC  = 2'b01,
      UOP_SHL  = 2'b10,
      UOP_SHR  = 2'b11
   } uop_e;

   // Mux build variants
   localparam int MUX_LOOP   = 0;
   localparam int MUX_ONEHOT = 1;

endpackage

// File: rtl/bdp_src_mux.sv
module bdp_src_mux
   import bus_dp_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int NUM_REGS  = 4,
   parameter int SEL_W     = 3,
   parameter int MUX_STYLE = MUX_ONEHOT
) (
   input  logic [SEL_W-1:0]           src_sel,
   input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
   input  logic [DATA_W-1:0]          ext_data,
   output logic [DATA_W-1:0]          bus
);

   localparam int NUM_SRC = NUM_REGS + 1;

   logic [DATA_W-1:0] srcs [NUM_SRC];

   genvar gi;
   generate
      for (gi = 0; gi < NUM_REGS; gi++) begin : g_src
         assign srcs[gi] = regs_flat[gi*DATA_W +: DATA_W];
      end
   endgenerate
   assign srcs[NUM_REGS] = ext_data;

   generate
      if (MUX_STYLE == MUX_ONEHOT) begin : g_onehot
         logic [NUM_SRC-1:0] sel_oh;
         logic [DATA_W-1:0]  partial [NUM_SRC+1];

         assign partial[0] = '0;
         for (gi = 0; gi < NUM_SRC; gi++) begin : g_andor
            assign sel_oh[gi]      = (src_sel == SEL_W'(gi));
            assign partial[gi + 1] = partial[gi] | ({DATA_W{sel_oh[gi]}} & srcs[gi]);
         end
         assign bus = partial[NUM_SRC];
      end else begin : g_loop
         always_comb begin
            bus = '0;
            for (int k = 0; k < NUM_SRC; k++) begin
               if (src_sel == SEL_W'(k)) begin
                  bus = srcs[k];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/bdp_uop_unit.sv
module bdp_uop_unit
   import bus_dp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [1:0]        uop,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   uop_e op;
   assign op = uop_e'(uop);

   always_comb begin
      unique case (op)
         UOP_PASS: dout = din;
         UOP_INC:  dout = din + DATA_W'(1);
         UOP_SHL:  dout = {din[DATA_W-2:0], 1'b0};
         UOP_SHR:  dout = {1'b0, din[DATA_W-1:1]};
         default:  dout = din;
      endcase
   end

endmodule

// File: rtl/bdp_reg_bank.sv
module bdp_reg_bank #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NUM_REGS-1:0]        load_en,
   input  logic [DATA_W-1:0]          din,
   output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
         logic [DATA_W-1:0] q;

         always_ff @(posedge clk) begin
            if (rst) begin
               q <= '0;
            end else if (load_en[gi]) begin
               q <= din;
            end
         end

         assign regs_flat[gi*DATA_W +: DATA_W] = q;
      end
   endgenerate

endmodule

// File: rtl/bus_xfer_dp.sv
module bus_xfer_dp
   import bus_dp_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int NUM_REGS  = 4,
   parameter int SEL_W     = 3,
   parameter int MUX_STYLE = MUX_ONEHOT
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [SEL_W-1:0]           src_sel,
   input  logic [1:0]                 uop,
   input  logic [NUM_REGS-1:0]        load_en,
   input  logic [DATA_W-1:0]          ext_data,
   output logic [DATA_W-1:0]          bus_out,
   output logic [NUM_REGS*DATA_W-1:0] regs_out
);

   localparam int NUM_SRC = NUM_REGS + 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("bus_xfer_dp: DATA_W must be at least 2");
      end
      if (NUM_REGS < 1) begin : g_bad_regs
         $error("bus_xfer_dp: NUM_REGS must be at least 1");
      end
      if (NUM_SRC > (1 << SEL_W)) begin : g_bad_sel
         $error("bus_xfer_dp: SEL_W too narrow for all sources");
      end
      if (MUX_STYLE != MUX_ONEHOT && MUX_STYLE != MUX_LOOP) begin : g_bad_style
         $error("bus_xfer_dp: unknown MUX_STYLE");
      end
   endgenerate

   logic [DATA_W-1:0]          bus;
   logic [DATA_W-1:0]          op_result;
   logic [NUM_REGS*DATA_W-1:0] regs_flat;

   bdp_src_mux #(
      .DATA_W    (DATA_W),
      .NUM_REGS  (NUM_REGS),
      .SEL_W     (SEL_W),
      .MUX_STYLE (MUX_STYLE)
   ) u_mux (
      .src_sel   (src_sel),
      .regs_flat (regs_flat),
      .ext_data  (ext_data),
      .bus       (bus)
   );

   bdp_uop_unit #(
      .DATA_W (DATA_W)
   ) u_uop (
      .uop  (uop),
      .din  (bus),
      .dout (op_result)
   );

   bdp_reg_bank #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_regs (
      .clk       (clk),
      .rst       (rst),
      .load_en   (load_en),
      .din       (op_result),
      .regs_flat (regs_flat)
   );

   assign bus_out  = bus;
   assign regs_out = regs_flat;

endmodule

// File: rtl/bdp_checker.sv
module bdp_checker #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 4,
   parameter int SEL_W    = 3
) (
   input logic                       clk,
   input logic                       rst,
   input logic [SEL_W-1:0]           src_sel,
   input logic [1:0]                 uop,
   input logic [NUM_REGS*DATA_W-1:0] regs_out,
   input logic [NUM_REGS-1:0]        load_en,
   input logic [DATA_W-1:0]          ext_data,
   input logic [DATA_W-1:0]          bus_out
);

   function automatic logic [DATA_W-1:0] ref_op(input logic [1:0] op,
                                                 input logic [DATA_W-1:0] v);
      case (op)
         2'b00:   ref_op = v;
         2'b01:   ref_op = v + 1'b1;
         2'b10:   ref_op = v << 1;
         default: ref_op = v >> 1;
      endcase
   endfunction

   logic [DATA_W-1:0] expect_next;
   assign expect_next = ref_op(uop, bus_out);

   logic rst_d = 1'b0;
   always_ff @(posedge clk) rst_d <= rst;

   // R1
   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      rst_d |-> (regs_out == '0));

   // R3
   assert_ext_on_bus_R3: assert property (@(posedge clk) disable iff (rst)
      (src_sel == SEL_W'(NUM_REGS)) |-> (bus_out == ext_data));

   // R4
   assert_empty_code_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (src_sel > SEL_W'(NUM_REGS)) |-> (bus_out == '0));

   genvar gi;
   generate
      for (gi = 0; gi < NUM_REGS; gi++) begin : g_chk
         // R2
         assert_reg_on_bus_R2: assert property (@(posedge clk) disable iff (rst)
            (src_sel == SEL_W'(gi)) |-> (bus_out == regs_out[gi*DATA_W +: DATA_W]));
         // R5 (hold)
         assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
            !load_en[gi] |=> $stable(regs_out[gi*DATA_W +: DATA_W]));
         // R5, R7..R11 (load of the operation result computed from the pre-edge bus)
         assert_load_R11: assert property (@(posedge clk) disable iff (rst)
            load_en[gi] |=> (regs_out[gi*DATA_W +: DATA_W] == $past(expect_next)));
      end
   endgenerate

endmodule

bind bus_xfer_dp bdp_checker #(
   .DATA_W   (DATA_W),
   .NUM_REGS (NUM_REGS),
   .SEL_W    (SEL_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .src_sel  (src_sel),
   .uop      (uop),
   .regs_out (regs_out),
   .load_en  (load_en),
   .ext_data (ext_data),
   .bus_out  (bus_out)
);

// File: tb/tb_bus_xfer_dp.sv
`timescale 1ns/1ps
module tb_bus_xfer_dp;

   localparam int DW = 8;
   localparam int NR = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [2:0]    src_sel = '0;
   logic [1:0]    uop = '0;
   logic [NR-1:0] load_en = '0;
   logic [DW-1:0] ext_data = '0;
   logic [DW-1:0] bus_out;
   logic [NR*DW-1:0] regs_out;

   int checks = 0;
   int failures = 0;
   logic [DW-1:0] m [NR];

   always #4 clk = ~clk;

   bus_xfer_dp dut (
      .clk      (clk),
      .rst      (rst),
      .src_sel  (src_sel),
      .uop      (uop),
      .load_en  (load_en),
      .ext_data (ext_data),
      .bus_out  (bus_out),
      .regs_out (regs_out)
   );

   task automatic chk(input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic r, input logic [2:0] sel, input logic [1:0] op,
                       input logic [NR-1:0] le, input logic [DW-1:0] x, input string tag);
      int b;
      int n;
      @(negedge clk);
      rst = r; src_sel = sel; uop = op; load_en = le; ext_data = x;
      #1;
      if (sel < NR)       b = m[sel];
      else if (sel == NR) b = x;
      else                b = 0;
      chk((sel < NR) ? "R2" : (sel == NR) ? "R3" : "R4", "bus", bus_out, b[DW-1:0]);
      case (op)
         2'd0: n = b;
         2'd1: n = (b + 1) % 256;
         2'd2: n = (b * 2) % 256;
         default: n = b / 2;
      endcase
      for (int i = 0; i < NR; i++) begin
         if (r) m[i] = '0;
         else if (le[i]) m[i] = n[DW-1:0];
      end
      @(posedge clk);
      #1;
      for (int i = 0; i < NR; i++) begin
         chk(r ? "R1" : le[i] ? tag : "R5", $sformatf("reg%0d", i),
             regs_out[i*DW +: DW], m[i]);
      end
   endtask

   initial begin
      #(8 * 100000);
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < NR; i++) m[i] = '0;
      // R1: reset wins over loads
      step(1'b1, 3'd4, 2'd0, 4'hF, 8'hAA, "R1");
      step(1'b1, 3'd4, 2'd0, 4'hF, 8'h33, "R1");
      // R5 R7: single load, others hold
      step(1'b0, 3'd4, 2'd0, 4'b0001, 8'h5A, "R7");
      // R6: three destinations at once
      step(1'b0, 3'd4, 2'd0, 4'b1110, 8'hFF, "R6");
      // R8: wrap of all-ones, source is also destination
      step(1'b0, 3'd1, 2'd1, 4'b0010, 8'h00, "R8");
      // R9: shift toward MSB
      step(1'b0, 3'd0, 2'd2, 4'b0100, 8'h00, "R9");
      // R10: shift toward LSB
      step(1'b0, 3'd0, 2'd3, 4'b1000, 8'h00, "R10");
      // R11: source and another register load together
      step(1'b0, 3'd0, 2'd1, 4'b0011, 8'h00, "R11");
      // R4: empty codes give zero
      step(1'b0, 3'd5, 2'd0, 4'b1000, 8'hC3, "R4");
      step(1'b0, 3'd6, 2'd1, 4'b0100, 8'hC3, "R4");
      step(1'b0, 3'd7, 2'd2, 4'b0001, 8'hC3, "R4");
      // R2: each register on the bus, no loads
      for (int i = 0; i < NR; i++) step(1'b0, 3'(i), 2'd0, 4'b0000, 8'h11, "R2");
      // R9 R10: bits falling off the ends
      step(1'b0, 3'd4, 2'd2, 4'b0001, 8'h81, "R9");
      step(1'b0, 3'd4, 2'd3, 4'b0010, 8'h81, "R10");
      // R11: chain where the source shifts itself
      step(1'b0, 3'd1, 2'd3, 4'b1110, 8'h00, "R11");
      // R5: mixed traffic
      for (int t = 0; t < 300; t++) begin
         step(1'b0, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
              4'($urandom_range(0, 15)), 8'($urandom_range(0, 255)), "R5");
      end
      // R1: reset in the middle of a run
      step(1'b1, 3'd2, 2'd1, 4'hF, 8'h77, "R1");
      step(1'b0, 3'd3, 2'd1, 4'b0000, 8'h00, "R5");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule